// File: doc/BRIEF.md
# Multi-Port RAM with Invalidation-Updated Bank Table

This block is a memory with several write ports and several read ports that all act in the same clock cycle. It is built only from simple RAM arrays, each with one write port and one read port. Every write port has its own data bank. Each bank is copied once for every read port, so no two read ports ever share one array read port.

A bank table records, for every address, which write port stored the newest value there. Each read port reads its own copy of that table in step with its data banks. It then picks the matching bank's output. The table is kept in one-write RAM arrays as well. Each write port updates only its own table copy, and it invalidates the other ports' claims by storing a value worked out from what their copies hold at that address.

The table has two encodings, chosen by a parameter. In the binary encoding, each copy holds a port index, and the newest writer is the exclusive-or of all copies. In the flag encoding, each copy holds one flag bit per other port, and pairwise flag comparisons name the newest writer.

Top module: `mpram`

## Requirements
- R1: A value written through any write port at address A is returned by a read port that presents A in any later cycle, up to the next write to A.
- R2: Read data appears on `rd_data` in the cycle after the edge that samples `rd_addr`, and stays fixed until the next edge.
- R3: A read of address A in the same cycle as a write to A returns the value A held before that write.
- R4: When different write ports write the same address in different cycles, reads return the value of the most recent write.
- R5: Read ports act independently. Read ports that present the same address in a cycle return equal data.
- R6: Both table encodings (`ENC` = `LVT_BINARY`, value 0, and `LVT_FLAGS`, value 1) give identical read results for identical traffic.
- R7: A write port whose `wr_en` bit is 0 changes no stored value, whatever its address and data lines carry.
- R8: While `rst` is high, `rd_data` is all zeros from the first edge on, and writes are ignored.
- R9: Write ports that target distinct addresses in the same cycle all store their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | N_WR | Write enable, bit w for write port w |
| wr_addr | input | N_WR*AW | Write addresses, port w in bits [w*AW +: AW] |
| wr_data | input | N_WR*WIDTH | Write data, port w in bits [w*WIDTH +: WIDTH] |
| rd_addr | input | N_RD*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | N_RD*WIDTH | Read data, port r in bits [r*WIDTH +: WIDTH], one cycle after its address |

## Verification
A read and a write can fall on the same address in the same cycle, and so can reads on several ports. Both cases have to resolve against the table, which the write is updating at that same edge. The bench provokes these collisions with directed cycles and by confining random read and write addresses to a small range. Each read is judged against a behavioural array model that returns the value held before the write at that edge. Two instances, one per table encoding, get the same traffic, and both are compared to the model on every cycle.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

    typedef enum logic [0:0] {
        LVT_BINARY = 1'b0,
        LVT_FLAGS  = 1'b1
    } lvt_enc_e;

    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mpram_sdp.sv
module mpram_sdp #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 8,
    parameter bit REG_RD = 1'b1,
    localparam int AW    = mpram_pkg::idx_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    generate
        if (REG_RD) begin : g_sync
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= mem[raddr];
            end
            assign rdata = q;
        end else begin : g_async
            logic unused_rst;
            assign unused_rst = rst;
            assign rdata = mem[raddr];
        end
    endgenerate
endmodule

// File: rtl/mpram_lvt_bin.sv
module mpram_lvt_bin #(
    parameter int N_WR  = 2,
    parameter int N_RD  = 2,
    parameter int DEPTH = 16,
    localparam int AW   = mpram_pkg::idx_bits(DEPTH),
    localparam int SW   = mpram_pkg::idx_bits(N_WR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_WR-1:0]      wr_en,
    input  logic [N_WR*AW-1:0]   wr_addr,
    input  logic [N_RD*AW-1:0]   rd_addr,
    output logic [N_RD*N_WR-1:0] sel_oh
);
    logic [SW-1:0] fb [N_WR][N_WR];
    logic [SW-1:0] rq [N_WR][N_RD];
    logic [SW-1:0] wv [N_WR];

    generate
        for (genvar c = 0; c < N_WR; c++) begin : g_copy
            for (genvar j = 0; j < N_WR; j++) begin : g_fb
                if (j != c) begin : g_ram
                    mpram_sdp #(.DEPTH(DEPTH), .WIDTH(SW), .REG_RD(1'b0)) u_fb (
                        .clk(clk), .rst(rst), .we(wr_en[c]),
                        .waddr(wr_addr[c*AW +: AW]), .wdata(wv[c]),
                        .raddr(wr_addr[j*AW +: AW]), .rdata(fb[c][j]));
                end else begin : g_self
                    assign fb[c][j] = '0;
                end
            end
            for (genvar r = 0; r < N_RD; r++) begin : g_rd
                mpram_sdp #(.DEPTH(DEPTH), .WIDTH(SW), .REG_RD(1'b1)) u_rd (
                    .clk(clk), .rst(rst), .we(wr_en[c]),
                    .waddr(wr_addr[c*AW +: AW]), .wdata(wv[c]),
                    .raddr(rd_addr[r*AW +: AW]), .rdata(rq[c][r]));
            end
        end
    endgenerate

    // new entry makes the XOR over all copies equal the writer's index
    always_comb begin
        for (int w = 0; w < N_WR; w++) begin
            wv[w] = SW'(w);
            for (int v = 0; v < N_WR; v++) wv[w] = wv[w] ^ fb[v][w];
        end
    end

    always_comb begin
        for (int r = 0; r < N_RD; r++) begin
            logic [SW-1:0] idx;
            idx = '0;
            for (int c = 0; c < N_WR; c++) idx = idx ^ rq[c][r];
            for (int w = 0; w < N_WR; w++) sel_oh[r*N_WR + w] = (idx == SW'(w));
        end
    end
endmodule

// File: rtl/mpram_lvt_flag.sv
module mpram_lvt_flag #(
    parameter int N_WR  = 2,
    parameter int N_RD  = 2,
    parameter int DEPTH = 16,
    localparam int AW   = mpram_pkg::idx_bits(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_WR-1:0]      wr_en,
    input  logic [N_WR*AW-1:0]   wr_addr,
    input  logic [N_RD*AW-1:0]   rd_addr,
    output logic [N_RD*N_WR-1:0] sel_oh
);
    // copy c, bit v: c's half of the pairwise age flag shared with port v
    logic [N_WR-1:0] fb [N_WR][N_WR];
    logic [N_WR-1:0] rq [N_WR][N_RD];
    logic [N_WR-1:0] wv [N_WR];
    logic            unused_fold;

    generate
        for (genvar c = 0; c < N_WR; c++) begin : g_copy
            for (genvar j = 0; j < N_WR; j++) begin : g_fb
                if (j != c) begin : g_ram
                    mpram_sdp #(.DEPTH(DEPTH), .WIDTH(N_WR), .REG_RD(1'b0)) u_fb (
                        .clk(clk), .rst(rst), .we(wr_en[c]),
                        .waddr(wr_addr[c*AW +: AW]), .wdata(wv[c]),
                        .raddr(wr_addr[j*AW +: AW]), .rdata(fb[c][j]));
                end else begin : g_self
                    assign fb[c][j] = '0;
                end
            end
            for (genvar r = 0; r < N_RD; r++) begin : g_rd
                mpram_sdp #(.DEPTH(DEPTH), .WIDTH(N_WR), .REG_RD(1'b1)) u_rd (
                    .clk(clk), .rst(rst), .we(wr_en[c]),
                    .waddr(wr_addr[c*AW +: AW]), .wdata(wv[c]),
                    .raddr(rd_addr[r*AW +: AW]), .rdata(rq[c][r]));
            end
        end
    endgenerate

    // pair (a<b): a is newer when flags differ, b is newer when they match
    always_comb begin
        for (int w = 0; w < N_WR; w++) begin
            for (int v = 0; v < N_WR; v++) begin
                if (v == w)     wv[w][v] = 1'b0;
                else if (w < v) wv[w][v] = ~fb[v][w][w];
                else            wv[w][v] =  fb[v][w][w];
            end
        end
    end

    always_comb begin
        for (int r = 0; r < N_RD; r++) begin
            for (int w = 0; w < N_WR; w++) begin
                logic win;
                win = 1'b1;
                for (int v = 0; v < N_WR; v++) begin
                    if (w < v)      win = win & (rq[w][r][v] != rq[v][r][w]);
                    else if (w > v) win = win & (rq[w][r][v] == rq[v][r][w]);
                end
                sel_oh[r*N_WR + w] = win;
            end
        end
    end

    always_comb begin
        unused_fold = 1'b0;
        for (int a = 0; a < N_WR; a++) begin
            for (int b = 0; b < N_WR; b++) unused_fold = unused_fold ^ (^fb[a][b]);
            for (int r = 0; r < N_RD; r++) unused_fold = unused_fold ^ (^rq[a][r]);
        end
    end
endmodule

// File: rtl/mpram.sv
module mpram #(
    parameter int N_WR  = 2,
    parameter int N_RD  = 2,
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter mpram_pkg::lvt_enc_e ENC = mpram_pkg::LVT_BINARY,
    localparam int AW   = mpram_pkg::idx_bits(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_WR-1:0]       wr_en,
    input  logic [N_WR*AW-1:0]    wr_addr,
    input  logic [N_WR*WIDTH-1:0] wr_data,
    input  logic [N_RD*AW-1:0]    rd_addr,
    output logic [N_RD*WIDTH-1:0] rd_data
);
    logic [N_WR-1:0]      wr_en_g;
    logic [N_RD*N_WR-1:0] sel_oh;
    logic [WIDTH-1:0]     bq [N_WR][N_RD];

    assign wr_en_g = rst ? '0 : wr_en;

    generate
        if (ENC == mpram_pkg::LVT_BINARY) begin : g_lvt_bin
            mpram_lvt_bin #(.N_WR(N_WR), .N_RD(N_RD), .DEPTH(DEPTH)) u_lvt (
                .clk(clk), .rst(rst), .wr_en(wr_en_g), .wr_addr(wr_addr),
                .rd_addr(rd_addr), .sel_oh(sel_oh));
        end else begin : g_lvt_flag
            mpram_lvt_flag #(.N_WR(N_WR), .N_RD(N_RD), .DEPTH(DEPTH)) u_lvt (
                .clk(clk), .rst(rst), .wr_en(wr_en_g), .wr_addr(wr_addr),
                .rd_addr(rd_addr), .sel_oh(sel_oh));
        end

        for (genvar w = 0; w < N_WR; w++) begin : g_bank
            for (genvar r = 0; r < N_RD; r++) begin : g_rep
                mpram_sdp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .REG_RD(1'b1)) u_ram (
                    .clk(clk), .rst(rst), .we(wr_en_g[w]),
                    .waddr(wr_addr[w*AW +: AW]), .wdata(wr_data[w*WIDTH +: WIDTH]),
                    .raddr(rd_addr[r*AW +: AW]), .rdata(bq[w][r]));
            end
        end
    endgenerate

    always_comb begin
        for (int r = 0; r < N_RD; r++) begin
            logic [WIDTH-1:0] acc;
            acc = '0;
            for (int w = 0; w < N_WR; w++) begin
                if (sel_oh[r*N_WR + w]) acc = acc | bq[w][r];
            end
            rd_data[r*WIDTH +: WIDTH] = acc;
        end
    end
endmodule

// File: rtl/mpram_chk.sv
module mpram_chk #(
    parameter int N_WR  = 2,
    parameter int N_RD  = 2,
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = mpram_pkg::idx_bits(DEPTH)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N_WR-1:0]       wr_en,
    input logic [N_WR*AW-1:0]    wr_addr,
    input logic [N_WR*WIDTH-1:0] wr_data,
    input logic [N_RD*AW-1:0]    rd_addr,
    input logic [N_RD*WIDTH-1:0] rd_data
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    // R8: output cleared once a reset edge has passed
    always_ff @(negedge clk) begin
        if (rst_q && rst) assert_rst_zero_R8: assert (rd_data == '0);
    end

    generate
        for (genvar r = 1; r < N_RD; r++) begin : g_same
            assert_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
                (rd_addr[r*AW +: AW] == rd_addr[0 +: AW])
                |=> (rd_data[r*WIDTH +: WIDTH] == rd_data[0 +: WIDTH]));
        end
        for (genvar r = 0; r < N_RD; r++) begin : g_rp
            assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (rst)
                (wr_en == '0) ##1 $stable(rd_addr[r*AW +: AW])
                |=> $stable(rd_data[r*WIDTH +: WIDTH]));
            for (genvar w = 0; w < N_WR; w++) begin : g_wp
                assert_wr_then_rd_R1: assert property (@(posedge clk) disable iff (rst)
                    wr_en[w] ##1 (rd_addr[r*AW +: AW] == $past(wr_addr[w*AW +: AW]))
                    |=> (rd_data[r*WIDTH +: WIDTH] == $past(wr_data[w*WIDTH +: WIDTH], 2)));
            end
        end
    endgenerate
endmodule

bind mpram mpram_chk #(.N_WR(N_WR), .N_RD(N_RD), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

// File: tb/mpram_bench.sv
`timescale 1ns/1ps
module mpram_bench;
    localparam int NW = 3;
    localparam int NR = 2;
    localparam int DP = 16;
    localparam int DW = 8;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NW-1:0]    wr_en = '0;
    logic [NW*AW-1:0] wr_addr = '0;
    logic [NW*DW-1:0] wr_data = '0;
    logic [NR*AW-1:0] rd_addr = '0;
    logic [NR*DW-1:0] rd_bin, rd_flag;

    int vectors = 0;
    int fails = 0;
    logic [DW-1:0] model [DP];
    bit            known [DP];

    always #2 clk = ~clk;

    mpram #(.N_WR(NW), .N_RD(NR), .DEPTH(DP), .WIDTH(DW),
            .ENC(mpram_pkg::LVT_BINARY)) u_mpram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_bin));

    mpram #(.N_WR(NW), .N_RD(NR), .DEPTH(DP), .WIDTH(DW),
            .ENC(mpram_pkg::LVT_FLAGS)) u_mpram_flag (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_flag));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_wr(input int w, input bit en, input int a, input int d);
        wr_en[w] = en;
        wr_addr[w*AW +: AW] = AW'(a);
        wr_data[w*DW +: DW] = DW'(d);
    endtask

    task automatic set_rd(input int r, input int a);
        rd_addr[r*AW +: AW] = AW'(a);
    endtask

    // one clock: expectations from the model before this edge's writes (R2, R3)
    task automatic tick(input string req);
        logic [DW-1:0] exp [NR];
        bit            chk [NR];
        for (int r = 0; r < NR; r++) begin
            exp[r] = model[rd_addr[r*AW +: AW]];
            chk[r] = known[rd_addr[r*AW +: AW]];
        end
        @(posedge clk);
        for (int w = 0; w < NW; w++) begin
            if (wr_en[w]) begin
                model[wr_addr[w*AW +: AW]] = wr_data[w*DW +: DW];
                known[wr_addr[w*AW +: AW]] = 1'b1;
            end
        end
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            if (chk[r]) begin
                check({req, " bin"},  rd_bin[r*DW +: DW],  exp[r]);
                check({req, " flag"}, rd_flag[r*DW +: DW], exp[r]);
            end
        end
        wr_en = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DP; i++) begin model[i] = '0; known[i] = 1'b0; end
        // R8: reset clears the output and blocks writes
        set_wr(0, 1'b1, 5, 8'h77);
        repeat (3) @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            check("R8 reset bin",  rd_bin[r*DW +: DW],  '0);
            check("R8 reset flag", rd_flag[r*DW +: DW], '0);
        end
        wr_en = '0;
        rst = 1'b0;

        // R9: all ports write distinct addresses in one cycle
        for (int w = 0; w < NW; w++) set_wr(w, 1'b1, w, 8'h10 + w);
        tick("R9");
        for (int w = 0; w < NW; w++) begin
            set_rd(0, w); set_rd(1, w);
            tick("R1 R5 R9");
        end
        // R8: the write attempted in reset left address 5 unwritten; now store and read it
        set_wr(1, 1'b1, 5, 8'hA5);
        tick("R1");
        set_rd(0, 5); set_rd(1, 5);
        tick("R1 R2 R5");
        // R3: read during write of the same address returns old data
        set_wr(2, 1'b1, 5, 8'h3C);
        tick("R3");
        tick("R4");
        // R4: ports take turns on one address
        for (int w = 0; w < NW; w++) begin
            set_wr(w, 1'b1, 9, 8'hC0 + w);
            tick("R4 write");
            set_rd(0, 9); set_rd(1, 2);
            tick("R4");
        end
        set_wr(0, 1'b1, 9, 8'hEE);
        tick("R4 wrap");
        tick("R4 wrap");
        // R7: disabled ports with live address and data change nothing
        set_wr(0, 1'b0, 9, 8'h01); set_wr(1, 1'b0, 9, 8'h02); set_wr(2, 1'b0, 5, 8'h03);
        tick("R7");
        set_rd(0, 9); set_rd(1, 5);
        tick("R7");
        tick("R7");

        // random traffic over a narrow address range to force collisions (R6)
        for (int n = 0; n < 4000; n++) begin
            bit used [DP];
            for (int i = 0; i < DP; i++) used[i] = 1'b0;
            for (int w = 0; w < NW; w++) begin
                int a;
                a = $urandom_range(0, 7);
                if (($urandom_range(0, 3) != 0) && !used[a]) begin
                    used[a] = 1'b1;
                    set_wr(w, 1'b1, a, $urandom_range(0, 255));
                end else begin
                    set_wr(w, 1'b0, a, $urandom_range(0, 255));
                end
            end
            for (int r = 0; r < NR; r++) set_rd(r, $urandom_range(0, 7));
            tick("R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule